// File: doc/BRIEF.md
# Power-of-Two Serial Clock Generator

This block produces the serial clock for a flash or SPI-style interface from the fast reference clock. The divide ratio is a power of two. A small code `k` selects a full SCLK period of `2 << k` reference cycles, so the fastest setting is half the reference rate. Two configuration bits set the clock polarity (the idle level) and the clock phase (whether data is captured on the first or the second edge of each bit).

Next to SCLK the block drives two single-cycle strobes, launch and sample. A neighbouring shifter uses them to know when to drive its next bit and when to capture the incoming one. A sequencer asks for clocking by holding `run` high. When `run` drops, the block finishes the half period in progress and parks SCLK at its idle level. It never emits a shortened pulse. The `en` input is a hard gate: dropping it silences the block at once.

Top module: `pow2_sclk_gen`

## Requirements
- R1: After reset, sclk is 0 and neither strobe is asserted; the reset configuration is divide code 0, polarity 0, phase 0.
- R2: While not running, sclk follows the polarity input one cycle later and no strobe is asserted.
- R3: With divide code k, every sclk level lasts exactly `1 << k` reference cycles, so the period is `2 << k` (ratios 2 to 256 for a 3-bit code). The first edge appears `1 << k` cycles after the clock edge at which run is first seen high.
- R4: With phase 0, a sample strobe accompanies every leading edge (away from the idle level) and a launch strobe accompanies every trailing edge.
- R5: With phase 1, a launch strobe accompanies every leading edge and a sample strobe accompanies every trailing edge.
- R6: Divide code, polarity and phase are captured only while idle. Changes to them during a run have no effect on edge timing, levels or strobes.
- R7: When run drops, the current half period completes. If sclk is then away from the idle level, it returns with one trailing edge and its strobe. Otherwise it stops with no further edge. No level is ever shorter than `1 << k` cycles.
- R8: With en low, the next cycle shows sclk at the polarity input level with no strobes, and run is ignored.
- R9: Launch and sample are each one reference cycle wide, are never asserted together, and appear only in the cycle in which sclk changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low forces idle immediately |
| div_code | input | DIV_W | Divide code k; SCLK period is `2 << k` cycles |
| cpol | input | 1 | Clock polarity; idle level of sclk |
| cpha | input | 1 | Clock phase; 0 samples on the leading edge, 1 on the trailing edge |
| run | input | 1 | Clock request from the sequencer |
| sclk | output | 1 | Serial clock, registered |
| launch_stb | output | 1 | One-cycle strobe: drive the next data bit |
| sample_stb | output | 1 | One-cycle strobe: capture the incoming data bit |

## Verification
The hardest case is dropping run at the right moment. Run must fall while SCLK sits away from its idle level, so that the stop has to produce one final trailing edge with the matching strobe instead of simply halting. The stimulus computes, from the drop cycle and the half-period length, which of the two stop cases each run lands in. Runs are then placed so that both cases occur at several divide codes. A second run changes the divide code and polarity in the middle of a burst and expects the edge timing to remain untouched.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int SCLK_DIV_W = 3;

  typedef enum logic {
    EDGE_LEAD  = 1'b0,
    EDGE_TRAIL = 1'b1
  } sclk_edge_e;

  // Phase 0: launch on trailing edges; phase 1: launch on leading edges.
  function automatic logic launch_on(sclk_edge_e e, logic pha);
    return (e == EDGE_LEAD) ? pha : !pha;
  endfunction
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst)       data_q <= '0;
    else if (load) data_q <= data_i;
  end
endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W:0]   half_len;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] cnt;

  assign half_len = {{CNT_W{1'b0}}, 1'b1} << div;
  assign last     = CNT_W'(half_len - {{CNT_W{1'b0}}, 1'b1});
  assign tick     = active && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !active || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R3: the counter never runs past the end of a half period
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= last));
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen
  import sclk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic run,
  input  logic tick,
  input  logic cpol_i,
  input  logic cpol_q,
  input  logic cpha_q,
  output logic active_q,
  output logic sclk_q,
  output logic launch_q,
  output logic sample_q
);
  sclk_edge_e kind;
  logic       lnch;

  assign kind = (sclk_q == cpol_q) ? EDGE_LEAD : EDGE_TRAIL;
  assign lnch = launch_on(kind, cpha_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      launch_q <= 1'b0;
      sample_q <= 1'b0;
      if (!en) begin
        active_q <= 1'b0;
        sclk_q   <= cpol_i;
      end else if (!active_q) begin
        sclk_q <= cpol_i;
        if (run) active_q <= 1'b1;
      end else if (tick) begin
        if (run) begin
          sclk_q   <= ~sclk_q;
          launch_q <= lnch;
          sample_q <= ~lnch;
        end else begin
          active_q <= 1'b0;
          if (kind == EDGE_TRAIL) begin
            sclk_q   <= cpol_q;
            launch_q <= lnch;
            sample_q <= ~lnch;
          end
        end
      end
    end
  end

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !(launch_q && sample_q));
  assert_strobe_on_edge_R9: assert property (@(posedge clk) disable iff (rst)
    (launch_q || sample_q) |-> (sclk_q != $past(sclk_q)));
  assert_edge_has_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(active_q) && $past(en) && (sclk_q != $past(sclk_q))) |-> (launch_q || sample_q));
  assert_en_stop_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!active_q && !launch_q && !sample_q && (sclk_q == $past(cpol_i))));
endmodule

// File: rtl/pow2_sclk_gen.sv
module pow2_sclk_gen
  import sclk_pkg::*;
#(
  parameter int DIV_W = SCLK_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_code,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             run,
  output logic             sclk,
  output logic             launch_stb,
  output logic             sample_stb
);
  localparam int CFG_W = DIV_W + 2;

  logic             active, tick, cpol_q, cpha_q;
  logic [DIV_W-1:0] div_q;
  logic [CFG_W-1:0] cfg_q;

  sclk_cfg_hold #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .load(!active || !en),
    .data_i({div_code, cpol, cpha}), .data_q(cfg_q)
  );
  assign {div_q, cpol_q, cpha_q} = cfg_q;

  sclk_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .active(active), .div(div_q), .tick(tick)
  );

  sclk_edge_gen u_edges (
    .clk(clk), .rst(rst), .en(en), .run(run), .tick(tick),
    .cpol_i(cpol), .cpol_q(cpol_q), .cpha_q(cpha_q),
    .active_q(active), .sclk_q(sclk),
    .launch_q(launch_stb), .sample_q(sample_stb)
  );

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
    !active |-> (sclk == cpol_q));
  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> ($stable(div_q) && $stable(cpol_q) && $stable(cpha_q)));
endmodule

// File: tb/pow2_sclk_gen_bench.sv
module pow2_sclk_gen_bench;
  localparam int DW = 3;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, cpol = 1'b0, cpha = 1'b0, run = 1'b0;
  logic [DW-1:0] div = '0;
  logic sclk, launch, sample;

  pow2_sclk_gen #(.DIV_W(DW)) u_pow2_sclk_gen (
    .clk(clk), .rst(rst), .en(en), .div_code(div), .cpol(cpol), .cpha(cpha),
    .run(run), .sclk(sclk), .launch_stb(launch), .sample_stb(sample)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0;
  int q_cyc[$];
  bit q_sclk[$], q_l[$], q_s[$];
  string q_tag[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(int c, bit s, bit l, bit sm, string t);
    q_cyc.push_back(c); q_sclk.push_back(s); q_l.push_back(l);
    q_s.push_back(sm); q_tag.push_back(t);
  endtask

  // Monitor: every sclk change or strobe is an event popped from the scoreboard
  bit sclk_prev = 1'b0;
  always @(negedge clk) begin
    if (mon_on && ((sclk !== sclk_prev) || launch || sample)) begin
      if (q_cyc.size() == 0) begin
        check(1'b0, "R7", "unexpected edge at cycle", cyc, -1);
      end else begin
        int ec; bit es, el, esm; string et;
        ec = q_cyc.pop_front(); es = q_sclk.pop_front();
        el = q_l.pop_front(); esm = q_s.pop_front(); et = q_tag.pop_front();
        check(cyc == ec, et, "edge cycle", cyc, ec);
        check(sclk == es, et, "sclk level", int'(sclk), int'(es));
        check(launch == el, et, "launch strobe", int'(launch), int'(el));
        check(sample == esm, et, "sample strobe", int'(sample), int'(esm));
        check(!(launch && sample), "R9", "both strobes", 1, 0);
      end
    end
    sclk_prev = sclk;
  end

  // Driver: one burst, run held for m cycles; optional mid-burst config changes
  task automatic burst(int d, bit pol, bit pha, int m, bit perturb, string tag);
    int k, h, i;
    @(negedge clk);
    div = DW'(d); cpol = pol; cpha = pha; en = 1'b1; run = 1'b0;
    repeat (2) @(negedge clk);
    k = cyc; h = 1 << d; i = 1;
    while (i * h <= m - 1) begin
      bit lead, ln;
      lead = (i % 2) == 1;
      ln = lead ? pha : !pha;
      push(k + 1 + i * h, pol ^ lead, ln, !ln, tag);
      i++;
    end
    if (((i - 1) % 2) == 1) push(k + 1 + i * h, pol, pha ? 1'b0 : 1'b1, pha, "R7");
    mon_on = 1'b1; run = 1'b1;
    if (perturb) begin
      @(negedge clk);
      div = ~DW'(d); cpol = ~pol; cpha = ~pha;
      repeat (m - 1) @(negedge clk);
      div = DW'(d); cpol = pol; cpha = pha;
    end else begin
      repeat (m) @(negedge clk);
    end
    run = 1'b0;
    repeat (2 * h + 4) @(negedge clk);
    check(q_cyc.size() == 0, tag, "edges missing", q_cyc.size(), 0);
    check(sclk == pol, "R7", "idle level after stop", int'(sclk), int'(pol));
    mon_on = 1'b0;
    q_cyc.delete(); q_sclk.delete(); q_l.delete(); q_s.delete(); q_tag.delete();
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
    check(!launch && !sample, "R1", "strobes in reset", int'(launch | sample), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R1", "sclk after reset", int'(sclk), 0);

    // R2: idle level follows polarity, no strobes
    en = 1'b1; cpol = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R2", "idle follows cpol=1", int'(sclk), 1);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check(!launch && !sample, "R2", "idle strobe", int'(launch | sample), 0);
    end
    cpol = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R2", "idle follows cpol=0", int'(sclk), 0);

    burst(0, 1'b0, 1'b0, 9,   1'b0, "R3/R4");
    burst(1, 1'b1, 1'b1, 10,  1'b0, "R3/R5");
    burst(2, 1'b0, 1'b1, 7,   1'b0, "R5/R7");
    burst(3, 1'b1, 1'b0, 20,  1'b0, "R4/R7");
    burst(7, 1'b0, 1'b0, 300, 1'b0, "R3");
    burst(1, 1'b0, 1'b0, 11,  1'b1, "R6");

    // R8: en low silences the block at once and run is ignored
    @(negedge clk);
    div = 3'd2; cpol = 1'b1; cpha = 1'b0; run = 1'b1;
    repeat (7) @(negedge clk);
    check(sclk == 1'b0, "R8", "running before en drop", int'(sclk), 0);
    en = 1'b0;
    @(negedge clk);
    check(sclk == 1'b1, "R8", "sclk at cpol after en drop", int'(sclk), 1);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      check(sclk == 1'b1 && !launch && !sample, "R8", "held idle with run high",
            int'({sclk, launch, sample}), 4);
    end
    run = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule